// File: doc/BRIEF.md
# EX-Stage Operand Bypass Selector

This block sits in the execute stage of a five-stage in-order pipeline. For each of the two ALU source operands it decides whether the value read from the register file is stale. When it is stale, the block picks up the result that a later stage still holds, before that result has been written back. It compares the two source register indices held for the instruction now entering execute against the destination index and write flag of the instruction one stage ahead (memory stage) and two stages ahead (write-back stage).

The block is purely combinational. It emits one 2-bit select per operand and also applies that select to the three candidate data words: the register file value, the memory-stage ALU result and the write-back value. The resolved operands can feed the ALU directly. When both later stages target the same register, the younger result, held in the memory stage, wins. Register 0 and instructions that write no register never act as a bypass source.

Top module: `ex_bypass_sel`

## Requirements
- R1: When the memory-stage write flag is 1, its destination index is nonzero and it equals an operand's source index, that operand's select is 2'b10.
- R2: When the write-back-stage write flag is 1, its destination index is nonzero and it equals an operand's source index, and R1 does not apply to that operand, the select is 2'b01.
- R3: When both stages match the same source index, the memory-stage source wins and the select is 2'b10.
- R4: A destination index of 0 never causes forwarding from that stage, whatever its write flag.
- R5: A stage whose write flag is 0 never causes forwarding, whatever its destination index.
- R6: When no stage qualifies, the select is 2'b00 and the operand equals the register file value.
- R7: Each resolved operand equals the register file value for select 00, the memory-stage result for 10 and the write-back value for 01. The select value 11 is never produced.
- R8: Operand A depends only on the first source index and operand B only on the second. Each operand is resolved by its own logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src1_idx | input | 5 | First source register index of the instruction in execute |
| src2_idx | input | 5 | Second source register index of the instruction in execute |
| mem_dst_idx | input | 5 | Destination index held in the memory stage |
| mem_dst_we | input | 1 | Memory-stage instruction writes a register |
| wb_dst_idx | input | 5 | Destination index held in the write-back stage |
| wb_dst_we | input | 1 | Write-back-stage instruction writes a register |
| rf_val_a | input | 64 | Register file value for the first source |
| rf_val_b | input | 64 | Register file value for the second source |
| mem_alu_val | input | 64 | ALU result held in the memory stage |
| wb_val | input | 64 | Value about to be written back |
| sel_a | output | 2 | Bypass select for operand A |
| sel_b | output | 2 | Bypass select for operand B |
| opnd_a | output | 64 | Resolved operand A |
| opnd_b | output | 64 | Resolved operand B |

## Verification
Directed cases cover a producer immediately ahead of its consumer, a producer two slots ahead, and both stages writing the same register. The last case separates a correct priority from one that favours the older value. Writes to register 0 and producers with the write flag cleared show that both qualifying conditions are present. Those cases use matching indices that would otherwise forward. Random index and flag patterns over a small register range make matches frequent. They check that the two operands stay independent and that each data word travels only through its own select.

// File: rtl/ex_bypass_sel.sv
module ex_bypass_sel #(
  parameter int XLEN   = 64,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0] src1_idx,
  input  logic [IDX_W-1:0] src2_idx,
  input  logic [IDX_W-1:0] mem_dst_idx,
  input  logic             mem_dst_we,
  input  logic [IDX_W-1:0] wb_dst_idx,
  input  logic             wb_dst_we,
  input  logic [XLEN-1:0]  rf_val_a,
  input  logic [XLEN-1:0]  rf_val_b,
  input  logic [XLEN-1:0]  mem_alu_val,
  input  logic [XLEN-1:0]  wb_val,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b,
  output logic [XLEN-1:0]  opnd_a,
  output logic [XLEN-1:0]  opnd_b
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic mem_live, wb_live;
  assign mem_live = mem_dst_we && (mem_dst_idx != ZERO_IDX);
  assign wb_live  = wb_dst_we  && (wb_dst_idx  != ZERO_IDX);

  function automatic logic [1:0] pick(input logic [IDX_W-1:0] src);
    if (mem_live && mem_dst_idx == src)     return SEL_MEM;
    else if (wb_live && wb_dst_idx == src)  return SEL_WB;
    else                                    return SEL_RF;
  endfunction

  function automatic logic [XLEN-1:0] route(input logic [1:0] sel,
                                            input logic [XLEN-1:0] rf);
    case (sel)
      SEL_MEM: return mem_alu_val;
      SEL_WB:  return wb_val;
      default: return rf;
    endcase
  endfunction

  assign sel_a  = pick(src1_idx);
  assign sel_b  = pick(src2_idx);
  assign opnd_a = route(sel_a, rf_val_a);
  assign opnd_b = route(sel_b, rf_val_b);
endmodule

module ex_bypass_sel_chk #(
  parameter int XLEN  = 64,
  parameter int IDX_W = 5
) (
  input logic [IDX_W-1:0] src1_idx,
  input logic [IDX_W-1:0] src2_idx,
  input logic [IDX_W-1:0] mem_dst_idx,
  input logic             mem_dst_we,
  input logic [IDX_W-1:0] wb_dst_idx,
  input logic             wb_dst_we,
  input logic [XLEN-1:0]  rf_val_a,
  input logic [XLEN-1:0]  mem_alu_val,
  input logic [XLEN-1:0]  wb_val,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b,
  input logic [XLEN-1:0]  opnd_a
);
  logic known;
  assign known = !$isunknown({src1_idx, src2_idx, mem_dst_idx, mem_dst_we,
                              wb_dst_idx, wb_dst_we, sel_a, sel_b});

  always_comb begin
    if (known) begin
      // R1 R3
      mem_hit_chk: assert (!(mem_dst_we && mem_dst_idx != 0 && mem_dst_idx == src1_idx) || sel_a == 2'b10);
      // R2
      wb_hit_chk: assert (sel_a != 2'b01 || (wb_dst_we && wb_dst_idx != 0 && wb_dst_idx == src1_idx));
      // R4
      zero_idx_chk: assert (src1_idx != 0 || sel_a == 2'b00);
      // R5
      no_write_chk: assert (mem_dst_we || wb_dst_we || (sel_a == 2'b00 && sel_b == 2'b00));
      // R7
      no_sel11_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
      // R7
      route_chk: assert ($isunknown({rf_val_a, mem_alu_val, wb_val}) ||
                         opnd_a == (sel_a == 2'b10 ? mem_alu_val :
                                    sel_a == 2'b01 ? wb_val : rf_val_a));
      // R8
      indep_chk: assert (src1_idx != src2_idx || sel_a == sel_b);
    end
  end
endmodule

bind ex_bypass_sel ex_bypass_sel_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .src1_idx(src1_idx), .src2_idx(src2_idx),
  .mem_dst_idx(mem_dst_idx), .mem_dst_we(mem_dst_we),
  .wb_dst_idx(wb_dst_idx), .wb_dst_we(wb_dst_we),
  .rf_val_a(rf_val_a), .mem_alu_val(mem_alu_val), .wb_val(wb_val),
  .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a)
);

// File: tb/ex_bypass_sel_tb.sv
module ex_bypass_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [4:0] src1_idx, src2_idx, mem_dst_idx, wb_dst_idx;
  logic mem_dst_we, wb_dst_we;
  logic [XLEN-1:0] rf_val_a, rf_val_b, mem_alu_val, wb_val;
  logic [1:0] sel_a, sel_b;
  logic [XLEN-1:0] opnd_a, opnd_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ex_bypass_sel u_dut (
    .src1_idx(src1_idx), .src2_idx(src2_idx),
    .mem_dst_idx(mem_dst_idx), .mem_dst_we(mem_dst_we),
    .wb_dst_idx(wb_dst_idx), .wb_dst_we(wb_dst_we),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
    .mem_alu_val(mem_alu_val), .wb_val(wb_val),
    .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [1:0] exp_sel(input logic [4:0] s, input logic [4:0] md,
                                         input logic mw, input logic [4:0] wd, input logic ww);
    if (mw && md != 0 && md == s) return 2'b10;
    if (ww && wd != 0 && wd == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] exp_val(input logic [1:0] s, input logic [XLEN-1:0] rf);
    return s == 2'b10 ? mem_alu_val : s == 2'b01 ? wb_val : rf;
  endfunction

  task automatic check(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [4:0] s1, input logic [4:0] s2,
                       input logic [4:0] md, input logic mw,
                       input logic [4:0] wd, input logic ww);
    @(negedge clk);
    src1_idx = s1; src2_idx = s2;
    mem_dst_idx = md; mem_dst_we = mw;
    wb_dst_idx = wd; wb_dst_we = ww;
    rf_val_a = {$urandom, $urandom}; rf_val_b = {$urandom, $urandom};
    mem_alu_val = {$urandom, $urandom}; wb_val = {$urandom, $urandom};
    #1;
  endtask

  task automatic check_both(input string req);
    logic [1:0] ea, eb;
    ea = exp_sel(src1_idx, mem_dst_idx, mem_dst_we, wb_dst_idx, wb_dst_we);
    eb = exp_sel(src2_idx, mem_dst_idx, mem_dst_we, wb_dst_idx, wb_dst_we);
    check({req, " sel_a"}, {62'd0, sel_a}, {62'd0, ea});
    check({req, " sel_b"}, {62'd0, sel_b}, {62'd0, eb});
    check({req, " opnd_a R7"}, opnd_a, exp_val(ea, rf_val_a));
    check({req, " opnd_b R7"}, opnd_b, exp_val(eb, rf_val_b));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R6 idle: no producers write
    apply(5'd3, 5'd4, 5'd0, 1'b0, 5'd0, 1'b0);
    check_both("R6 idle");
    check("R6 opnd_a is rf", opnd_a, rf_val_a);
    // R1 back-to-back producer on rs1
    apply(5'd7, 5'd9, 5'd7, 1'b1, 5'd12, 1'b1);
    check_both("R1 adjacent");
    check("R1 sel_a", {62'd0, sel_a}, 64'd2);
    // R2 producer two back on rs2
    apply(5'd7, 5'd9, 5'd15, 1'b1, 5'd9, 1'b1);
    check_both("R2 two-back");
    check("R2 sel_b", {62'd0, sel_b}, 64'd1);
    // R3 double hazard on both operands
    apply(5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1);
    check_both("R3 double");
    check("R3 opnd_b newest", opnd_b, mem_alu_val);
    // R4 write to x0 with sources x0
    apply(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    check_both("R4 x0");
    check("R4 opnd_a is rf", opnd_a, rf_val_a);
    // R4 memory stage targets x0, write-back stage real
    apply(5'd0, 5'd6, 5'd0, 1'b1, 5'd6, 1'b1);
    check_both("R4 mixed");
    // R5 matching indices but no write flags
    apply(5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0);
    check_both("R5 nowrite");
    check("R5 opnd_b is rf", opnd_b, rf_val_b);
    // R5 memory stage silent, write-back forwards
    apply(5'd8, 5'd2, 5'd8, 1'b0, 5'd8, 1'b1);
    check_both("R5 fallthrough");
    check("R5 sel_a wb", {62'd0, sel_a}, 64'd1);
    // R8 independent operands: A from mem, B from wb
    apply(5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1);
    check_both("R8 split");
    for (int i = 0; i < 400; i++) begin
      apply(5'($urandom_range(0, 5)), 5'($urandom_range(0, 5)),
            5'($urandom_range(0, 5)), 1'($urandom),
            5'($urandom_range(0, 5)), 1'($urandom));
      check_both("R8 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule